// File: doc/BRIEF.md
# Scanned Keyboard Matrix Encoder

This block walks a digital key-state matrix one switch position per clock. A column counter and a row counter do the stepping. The last column is reserved for function keys. Each time the scan passes that column, the state of the switch in each row is latched. The latched rows give three modifier bits (shift, upper case, control), three active-low function outputs (local, reset, break) and a repeat request. All other columns hold character keys.

A character closure is accepted only if the scan finds it closed on two consecutive visits. An accepted key is encoded by a small generated code table. The table is addressed by the modifier bits and the key's 16-key group; the low four bits of the scan position pass straight through. The code goes to an output latch, and an active-low ready strobe two clocks wide tells the host. The host reads the latch through a read-enable input.

While the repeat row is held, an accepted key repeats: its strobe is re-issued every `REPEAT_CYCLES` clocks and no new key is captured. Control sits in a four-state machine. IDLE goes to ARMED on the transition SEEN (a character key is found closed). ARMED goes to HELD on ACCEPT (the same key is closed on the next visit) or back to IDLE on BOUNCE (it is open). HELD goes to REPEAT on REP_ON (the repeat row is latched) or to IDLE on RELEASE (the key is found open). REPEAT goes back to HELD on REP_OFF or to IDLE on RELEASE.

Top module: `keyscan_encoder`

## Requirements
- R1: A synchronous active-high reset clears the output latch to 0x00 and the scan counters. It drives `strobe_n`, `fn_local_n`, `fn_reset_n` and `fn_break_n` high.
- R2: A character key is accepted only when found closed on two consecutive scan visits. A closure present for less than one scan period (`NCOLS*NROWS` clocks) produces no strobe.
- R3: A key held without the repeat row produces exactly one strobe per press, however long it is held.
- R4: Every strobe holds `strobe_n` low for exactly two consecutive clocks.
- R5: Key position p = column*NROWS + row, and bit p of `key_matrix` is 1 when the key is closed. Without modifiers, the code is {high, p[3:0]} with high = 3 for p[5:4]=0, 6 for p[5:4]=1 and 7 for p[5:4]=2.
- R6: Function-column row 0 (shift) or row 1 (shift lock) makes high = 2 for group 0, 4 for group 1 and 5 for group 2. Row 2 (upper case) does the same for groups 1 and 2 only. Row 3 (control) overrides both and gives high = p[4].
- R7: Keys in group 3 (the column next to the function column) produce high = 8, so bit 7 is set, whatever the modifiers.
- R8: Function-column rows 4, 5 and 6 drive `fn_local_n`, `fn_reset_n` and `fn_break_n` low while held, within one scan period. Function-column keys never produce a strobe.
- R9: With function-column row 7 (repeat) held together with a character key, strobes repeat every `REPEAT_CYCLES` clocks. The first repeat comes exactly one period after the initial strobe.
- R10: While repeating, the latched code does not change and other pressed keys are not captured.
- R11: `kbd_data` shows the latched code when `rd_en` is 1 and 0x00 when it is 0. The code changes only when a new strobe starts, and it survives key release.
- R12: After the accepted key is released, a still-held other key is accepted and encoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base scan clock |
| rst | input | 1 | Synchronous active-high reset |
| key_matrix | input | NCOLS*NROWS | Key closure state, bit column*NROWS+row, 1 = closed |
| rd_en | input | 1 | Host read select |
| kbd_data | output | 8 | Latched key code while selected, else zero |
| strobe_n | output | 1 | Active-low ready strobe, two clocks wide |
| fn_local_n | output | 1 | Active-low local function output |
| fn_reset_n | output | 1 | Active-low reset function output |
| fn_break_n | output | 1 | Active-low break function output |

## Verification
The bench runs a table of positions and modifier combinations. Among them are control overriding shift and a group-3 key that must ignore every modifier. A wrong table address or a wrong priority shows up there as a wrong high nibble.

Several cases are directed. A 40-clock closure must be rejected; a design that accepts on the first sighting strobes anyway. A long hold without repeat must give one strobe; a design that forgets the press strobes once per scan. In the repeat test, the spacing between strobes must be exactly `REPEAT_CYCLES`; an off-by-one counter drifts by one clock. A second key pressed during repeat must neither overwrite the code nor be lost after release.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ARMED,
        S_HELD,
        S_REPEAT
    } scan_state_e;

    localparam int ROW_SHIFT  = 0;
    localparam int ROW_LOCK   = 1;
    localparam int ROW_UPPER  = 2;
    localparam int ROW_CTRL   = 3;
    localparam int ROW_LOCAL  = 4;
    localparam int ROW_RESET  = 5;
    localparam int ROW_BREAK  = 6;
    localparam int ROW_REPEAT = 7;

    // High nibble for table address {ctrl, upper, shift, group}
    function automatic logic [3:0] hi_nibble(input int addr, input int gw);
        int grp;
        int sh;
        int up;
        int ct;
        grp = addr & ((1 << gw) - 1);
        sh  = (addr >> gw) & 1;
        up  = (addr >> (gw + 1)) & 1;
        ct  = (addr >> (gw + 2)) & 1;
        if (grp >= 3)            return 4'h8;
        if (ct != 0)             return 4'(grp & 1);
        if (grp == 0)            return (sh != 0) ? 4'h2 : 4'h3;
        if ((sh | up) != 0)      return 4'(3 + grp);
        return 4'(5 + grp);
    endfunction

endpackage

// File: rtl/keyscan_counter.sv
module keyscan_counter #(
    parameter int NCOLS = 8,
    parameter int NROWS = 8,
    localparam int COL_W = $clog2(NCOLS),
    localparam int ROW_W = $clog2(NROWS),
    localparam int POS_W = $clog2(NCOLS * NROWS)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row,
    output logic [POS_W-1:0] pos
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(NCOLS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
            col <= '0;
        end else if (row == ROW_LAST) begin
            row <= '0;
            col <= (col == COL_LAST) ? '0 : col + 1'b1;
        end else begin
            row <= row + 1'b1;
        end
    end

    always_comb pos = POS_W'(col) * POS_W'(NROWS) + POS_W'(row);

endmodule

// File: rtl/keyscan_fn_latch.sv
module keyscan_fn_latch #(
    parameter int NROWS = 8,
    localparam int ROW_W = $clog2(NROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ROW_W-1:0] row,
    input  logic             key_bit,
    output logic [NROWS-1:0] fn_q
);
    always_ff @(posedge clk) begin
        if (rst)     fn_q <= '0;
        else if (en) fn_q[row] <= key_bit;
    end
endmodule

// File: rtl/keyscan_code_rom.sv
module keyscan_code_rom #(
    parameter int GRP_W = 2,
    localparam int ADDR_W = GRP_W + 3,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic [2:0]       mods,
    input  logic [GRP_W-1:0] grp,
    output logic [3:0]       hi
);
    logic [3:0] table_q [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_tbl
        assign table_q[a] = keyscan_pkg::hi_nibble(a, GRP_W);
    end

    assign hi = table_q[{mods, grp}];
endmodule

// File: rtl/keyscan_encoder.sv
module keyscan_encoder #(
    parameter int NCOLS         = 8,
    parameter int NROWS         = 8,
    parameter int REPEAT_CYCLES = 20000,
    localparam int KEYS   = NCOLS * NROWS,
    localparam int COL_W  = $clog2(NCOLS),
    localparam int ROW_W  = $clog2(NROWS),
    localparam int POS_W  = $clog2(KEYS),
    localparam int GRP_W  = POS_W - 4,
    localparam int REP_W  = $clog2(REPEAT_CYCLES),
    localparam int STB_CYCLES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [KEYS-1:0] key_matrix,
    input  logic            rd_en,
    output logic [7:0]      kbd_data,
    output logic            strobe_n,
    output logic            fn_local_n,
    output logic            fn_reset_n,
    output logic            fn_break_n
);
    import keyscan_pkg::*;

    localparam logic [COL_W-1:0] FN_COL  = COL_W'(NCOLS - 1);
    localparam logic [REP_W-1:0] REP_TOP = REP_W'(REPEAT_CYCLES - 1);

    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic [POS_W-1:0] pos;
    logic [NROWS-1:0] fn_q;
    logic [3:0]       hi;
    logic             key_bit, is_char, hit, rep_mod, shift_eff;

    scan_state_e      state_q, state_d;
    logic [POS_W-1:0] cand_q;
    logic [7:0]       code_q;
    logic [1:0]       stb_cnt_q;
    logic [REP_W-1:0] rep_cnt_q;
    logic             accept, rep_fire;

    keyscan_counter #(.NCOLS(NCOLS), .NROWS(NROWS)) u_scan (
        .clk(clk), .rst(rst), .col(col), .row(row), .pos(pos)
    );

    keyscan_fn_latch #(.NROWS(NROWS)) u_fn (
        .clk(clk), .rst(rst), .en(col == FN_COL), .row(row),
        .key_bit(key_bit), .fn_q(fn_q)
    );

    assign shift_eff = fn_q[ROW_SHIFT] | fn_q[ROW_LOCK];

    keyscan_code_rom #(.GRP_W(GRP_W)) u_rom (
        .mods({fn_q[ROW_CTRL], fn_q[ROW_UPPER], shift_eff}),
        .grp(cand_q[POS_W-1:4]),
        .hi(hi)
    );

    assign key_bit = key_matrix[pos];
    assign is_char = (col != FN_COL);
    assign hit     = (pos == cand_q);
    assign rep_mod = fn_q[ROW_REPEAT];

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (key_bit && is_char) state_d = S_ARMED;          // SEEN
            S_ARMED:  if (hit) state_d = key_bit ? S_HELD : S_IDLE;       // ACCEPT / BOUNCE
            S_HELD: begin
                if (hit && !key_bit) state_d = S_IDLE;                    // RELEASE
                else if (rep_mod)    state_d = S_REPEAT;                  // REP_ON
            end
            S_REPEAT: begin
                if (hit && !key_bit) state_d = S_IDLE;                    // RELEASE
                else if (!rep_mod)   state_d = S_HELD;                    // REP_OFF
            end
        endcase
    end

    assign accept   = (state_q == S_ARMED) && hit && key_bit;
    assign rep_fire = (state_q == S_REPEAT) && (state_d == S_REPEAT) && (rep_cnt_q == REP_TOP);

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q    <= '0;
            code_q    <= '0;
            stb_cnt_q <= '0;
            rep_cnt_q <= '0;
        end else begin
            if (state_q == S_IDLE && key_bit && is_char) cand_q <= pos;
            if (accept) code_q <= {hi, cand_q[3:0]};

            if (accept || rep_fire)  stb_cnt_q <= 2'(STB_CYCLES);
            else if (stb_cnt_q != 0) stb_cnt_q <= stb_cnt_q - 1'b1;

            if (accept || rep_fire)
                rep_cnt_q <= '0;
            else if ((state_q == S_HELD || state_q == S_REPEAT) && rep_cnt_q != REP_TOP)
                rep_cnt_q <= rep_cnt_q + 1'b1;
        end
    end

    assign strobe_n   = (stb_cnt_q == 0);
    assign kbd_data   = rd_en ? code_q : 8'h00;
    assign fn_local_n = !fn_q[ROW_LOCAL];
    assign fn_reset_n = !fn_q[ROW_RESET];
    assign fn_break_n = !fn_q[ROW_BREAK];

endmodule

// File: rtl/keyscan_checker.sv
module keyscan_checker (
    input logic                     clk,
    input logic                     rst,
    input logic                     rd_en,
    input logic [7:0]               kbd_data,
    input logic                     strobe_n,
    input logic                     fn_local_n,
    input logic                     fn_reset_n,
    input logic                     fn_break_n,
    input keyscan_pkg::scan_state_e state_q,
    input logic [7:0]               code_q
);
    import keyscan_pkg::*;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (strobe_n && fn_local_n && fn_reset_n && fn_break_n)); // R1

    AST_FALL_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_n) |-> ($past(state_q) == S_ARMED || $past(state_q) == S_REPEAT)); // R2

    AST_STROBE_SECOND: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_n) |=> !strobe_n); // R4

    AST_STROBE_END: assert property (@(posedge clk) disable iff (rst)
        (!strobe_n && !$past(strobe_n)) |=> strobe_n); // R4

    AST_REPEAT_CODE: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_REPEAT && $past(state_q) == S_REPEAT) |-> $stable(code_q)); // R10

    AST_DATA_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en) && !$stable(kbd_data)) |-> $fell(strobe_n)); // R11

endmodule

bind keyscan_encoder keyscan_checker u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .kbd_data(kbd_data),
    .strobe_n(strobe_n), .fn_local_n(fn_local_n), .fn_reset_n(fn_reset_n),
    .fn_break_n(fn_break_n), .state_q(state_q), .code_q(code_q)
);

// File: tb/sim_keyscan_encoder.sv
module sim_keyscan_encoder;
    localparam int NC = 8, NR = 8, KEYS = 64, SCAN = 64, REP = 200;
    localparam int FN = 56;

    logic clk = 0, rst = 1, rd_en = 1;
    logic [KEYS-1:0] key_matrix = '0;
    logic [7:0] kbd_data;
    logic strobe_n, fn_local_n, fn_reset_n, fn_break_n;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int fall_cnt = 0, low_run = 0, last_width = 0;
    int fall_t [8];
    logic prev_stb = 1;

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    keyscan_encoder #(.NCOLS(NC), .NROWS(NR), .REPEAT_CYCLES(REP)) u0 (
        .clk(clk), .rst(rst), .key_matrix(key_matrix), .rd_en(rd_en),
        .kbd_data(kbd_data), .strobe_n(strobe_n), .fn_local_n(fn_local_n),
        .fn_reset_n(fn_reset_n), .fn_break_n(fn_break_n)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stb && !strobe_n) begin
                if (fall_cnt < 8) fall_t[fall_cnt] = cyc;
                fall_cnt++;
            end
            if (!strobe_n) low_run++;
            else if (low_run != 0) begin last_width = low_run; low_run = 0; end
            prev_stb = strobe_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {pos[5:0], fn rows[7:0], expected code[7:0]}
    localparam int NV = 12;
    localparam logic [21:0] VEC [NV] = '{
        {6'h05, 8'h00, 8'h35},  // R5 group 0
        {6'h05, 8'h01, 8'h25},  // R6 shift
        {6'h12, 8'h00, 8'h62},  // R5 group 1
        {6'h12, 8'h04, 8'h42},  // R6 upper
        {6'h12, 8'h02, 8'h42},  // R6 lock
        {6'h2A, 8'h00, 8'h7A},  // R5 group 2
        {6'h2A, 8'h01, 8'h5A},  // R6 shift
        {6'h2A, 8'h08, 8'h0A},  // R6 control
        {6'h13, 8'h09, 8'h13},  // R6 control over shift
        {6'h33, 8'h00, 8'h83},  // R7 special
        {6'h33, 8'h09, 8'h83},  // R7 modifiers ignored
        {6'h00, 8'h04, 8'h30}   // R6 upper leaves group 0
    };

    initial begin
        wait_cyc(3);
        rst = 0;
        wait_cyc(1);
        // R1 reset state
        chk(strobe_n == 1, "R1 strobe", strobe_n, 1);
        chk(kbd_data == 8'h00, "R1 data", kbd_data, 0);
        chk({fn_local_n, fn_reset_n, fn_break_n} == 3'b111, "R1 fn", {fn_local_n, fn_reset_n, fn_break_n}, 7);

        for (int i = 0; i < NV; i++) begin
            fall_cnt = 0;
            key_matrix[VEC[i][21:16]] = 1'b1;
            for (int r = 0; r < 8; r++) key_matrix[FN + r] = VEC[i][8 + r];
            wait_cyc(3 * SCAN);
            chk(fall_cnt == 1, "R2/R3 one strobe", fall_cnt, 1);
            chk(last_width == 2, "R4 width", last_width, 2);
            chk(kbd_data == VEC[i][7:0], "R5/R6/R7 code", kbd_data, VEC[i][7:0]);
            key_matrix = '0;
            wait_cyc(2 * SCAN);
        end

        // R11 code survives release, read select gates output
        chk(kbd_data == 8'h30, "R11 held after release", kbd_data, 8'h30);
        rd_en = 0;
        wait_cyc(1);
        chk(kbd_data == 8'h00, "R11 deselected", kbd_data, 0);
        rd_en = 1;

        // R2 short closure rejected
        fall_cnt = 0;
        key_matrix[6'h21] = 1'b1;
        wait_cyc(40);
        key_matrix = '0;
        wait_cyc(3 * SCAN);
        chk(fall_cnt == 0, "R2 short closure", fall_cnt, 0);
        chk(kbd_data == 8'h30, "R2 latch untouched", kbd_data, 8'h30);

        // R3 long hold, no repeat
        fall_cnt = 0;
        key_matrix[6'h07] = 1'b1;
        wait_cyc(6 * SCAN);
        chk(fall_cnt == 1, "R3 long hold", fall_cnt, 1);
        key_matrix = '0;
        wait_cyc(2 * SCAN);

        // R8 function outputs
        fall_cnt = 0;
        key_matrix[FN + 4] = 1'b1;
        key_matrix[FN + 6] = 1'b1;
        wait_cyc(SCAN + 4);
        chk({fn_local_n, fn_reset_n, fn_break_n} == 3'b010, "R8 local+break", {fn_local_n, fn_reset_n, fn_break_n}, 2);
        key_matrix = '0;
        key_matrix[FN + 5] = 1'b1;
        wait_cyc(SCAN + 4);
        chk({fn_local_n, fn_reset_n, fn_break_n} == 3'b101, "R8 reset", {fn_local_n, fn_reset_n, fn_break_n}, 5);
        chk(fall_cnt == 0, "R8 no strobe", fall_cnt, 0);
        key_matrix = '0;
        wait_cyc(2 * SCAN);

        // R9 / R10 repeat
        fall_cnt = 0;
        key_matrix[6'h05] = 1'b1;
        key_matrix[FN + 7] = 1'b1;
        wait_cyc(2 * SCAN + 20);
        key_matrix[6'h12] = 1'b1;
        wait_cyc(3 * REP + 10);
        chk(fall_cnt >= 3, "R9 repeat count", fall_cnt, 3);
        chk(fall_t[1] - fall_t[0] == REP, "R9 first period", fall_t[1] - fall_t[0], REP);
        chk(fall_t[2] - fall_t[1] == REP, "R9 next period", fall_t[2] - fall_t[1], REP);
        chk(last_width == 2, "R4 repeat width", last_width, 2);
        chk(kbd_data == 8'h35, "R10 code kept", kbd_data, 8'h35);

        // R12 release first key, second still held
        key_matrix[FN + 7] = 1'b0;
        key_matrix[6'h05] = 1'b0;
        wait_cyc(SCAN + 4);
        fall_cnt = 0;
        wait_cyc(3 * SCAN);
        chk(fall_cnt == 1, "R12 next key strobe", fall_cnt, 1);
        chk(kbd_data == 8'h62, "R12 next key code", kbd_data, 8'h62);
        key_matrix = '0;
        wait_cyc(2 * SCAN);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule